// File: doc/BRIEF.md
# Serial Port Pin Multiplexer

This block sits between a synchronous serial port's shift engine and four package pins. It decides, from the port enable, the master/slave mode bit and a transmit-enable bit, which pins are taken over by the serial function and which stay ordinary general-purpose I/O. It also decides when each taken pin actively drives its line. Each pin has a general-purpose output latch and a direction bit. While a pin serves the serial function, its latch must hold 1, the reset value. A latch left at 0 pulls that pin low.

In master mode the data-out and clock pins are driven from the engine. The data-in pin is only sampled. The slave-select pin stays general-purpose. In slave mode all four pins serve the serial function and the clock pin is input-only. The data-out pin stays high-impedance unless the synchronized slave-select level is low and transmit-enable is set. This lets several slaves share one select line, with only the intended one driving.

The pin indices are fixed: 0 is data-in, 1 is data-out, 2 is clock and 3 is slave-select. The control inputs are expected to come from registers. The slave-select pin is brought through a synchronizer before it gates anything.

Top module: `spi_pin_mux`

## Requirements
- R1: With `port_en` low, every pin follows its general-purpose direction and latch: `pad_oe[i]=gp_dir[i]` and `pad_out[i]=gp_latch[i]` for i = 0..3.
- R2: With `port_en` high and `master_mode` high, and each pin's latch at 1:
  - pin 1 is driven with `ser_dout`;
  - pin 2 is driven with `ser_sclk_out`.
- R3: With `port_en` high and `master_mode` high, pin 3 stays general-purpose (`pad_oe[3]=gp_dir[3]`, `pad_out[3]=gp_latch[3]`).
- R4: With `port_en` high, pin 0 (latch 1) is never driven, in either mode. `ser_din` always equals `pad_in[0]`.
- R5: In slave mode, with latch 1 on each pin, pins 2 and 3 are never driven. `ser_sclk_in` always equals `pad_in[2]`.
- R6: In slave mode with latch 1, pin 1 is driven with `ser_dout` exactly when the synchronized select level is 0 and `tx_en` is 1. Otherwise `pad_oe[1]` is 0.
- R7: A change of `pad_in[3]` reaches the output enables and `ser_sel_act` on the second rising clock edge after it is applied. `ser_sel_act` is 1 only in enabled slave mode with the synchronized select low.
- R8: With `port_en` high, a pin owned by the serial function whose latch is 0 is driven low (`pad_oe=1`, `pad_out=0`).
- R9: During and after reset the synchronized select reads inactive (1), so slave data-out is not driven until the select pin has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| master_mode | input | 1 | 1 = master, 0 = slave |
| tx_en | input | 1 | Slave transmit enable |
| ser_dout | input | 1 | Data-out value from the shift engine |
| ser_sclk_out | input | 1 | Master clock from the shift engine |
| gp_latch | input | 4 | General-purpose output latches, index = pin |
| gp_dir | input | 4 | General-purpose direction, 1 = output |
| pad_in | input | 4 | Sampled pin levels |
| pad_out | output | 4 | Pin output values |
| pad_oe | output | 4 | Pin drive enables |
| ser_din | output | 1 | Data-in level to the shift engine |
| ser_sclk_in | output | 1 | Clock pin level to the shift engine |
| ser_sel_act | output | 1 | Synchronized slave select active |

## Verification
The only state is the select synchronizer and its reset.

A stuck or mis-reset stage shows at the ports as a wrong `pad_oe[1]` or `ser_sel_act` in slave mode. This appears within two clock edges of a select change.

A wrong ownership or drive decision is purely combinational. It shows on `pad_oe` and `pad_out` in the same cycle as the input pattern that selects it. Random patterns over all mode, latch and direction combinations expose such a fault almost at once.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;
  localparam int unsigned NPINS = 4;

  typedef enum logic [1:0] {
    PIN_DIN  = 2'd0,
    PIN_DOUT = 2'd1,
    PIN_CLK  = 2'd2,
    PIN_SEL  = 2'd3
  } pin_idx_e;

  typedef logic [NPINS-1:0] pin_vec_t;
endpackage

// File: rtl/spi_pin_rst_sync.sv
module spi_pin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stage_d = d_async;
    end else begin : g_many
      always_comb stage_d = {stage_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route (
  input  logic ser_own,
  input  logic ser_drv,
  input  logic ser_val,
  input  logic latch,
  input  logic dir,
  output logic oe,
  output logic out
);
  always_comb begin
    if (!ser_own) begin
      oe  = dir;
      out = latch;
    end else if (!latch) begin
      oe  = 1'b1;
      out = 1'b0;
    end else begin
      oe  = ser_drv;
      out = ser_drv & ser_val;
    end
  end
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
  import spi_pin_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             master_mode,
  input  logic             tx_en,
  input  logic             ser_dout,
  input  logic             ser_sclk_out,
  input  logic [NPINS-1:0] gp_latch,
  input  logic [NPINS-1:0] gp_dir,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             ser_din,
  output logic             ser_sclk_in,
  output logic             ser_sel_act
);
  logic     rst_n_int;
  logic     sel_sync;
  logic     slave_on;
  logic     master_on;
  logic     dout_enable;
  pin_vec_t own_v;
  pin_vec_t drv_v;
  pin_vec_t val_v;

  spi_pin_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sel_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .d_async(pad_in[PIN_SEL]),
    .q_sync (sel_sync)
  );

  always_comb begin
    master_on   = port_en &  master_mode;
    slave_on    = port_en & ~master_mode;
    dout_enable = master_on | (slave_on & tx_en & ~sel_sync);

    own_v           = '0;
    own_v[PIN_DIN]  = port_en;
    own_v[PIN_DOUT] = port_en;
    own_v[PIN_CLK]  = port_en;
    own_v[PIN_SEL]  = slave_on;

    drv_v           = '0;
    drv_v[PIN_DOUT] = dout_enable;
    drv_v[PIN_CLK]  = master_on;

    val_v           = '0;
    val_v[PIN_DOUT] = ser_dout;
    val_v[PIN_CLK]  = ser_sclk_out;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      spi_pin_route u_route (
        .ser_own(own_v[gi]),
        .ser_drv(drv_v[gi]),
        .ser_val(val_v[gi]),
        .latch  (gp_latch[gi]),
        .dir    (gp_dir[gi]),
        .oe     (pad_oe[gi]),
        .out    (pad_out[gi])
      );
    end
  endgenerate

  assign ser_din     = pad_in[PIN_DIN];
  assign ser_sclk_in = pad_in[PIN_CLK];
  assign ser_sel_act = slave_on & ~sel_sync;
endmodule

// File: rtl/spi_pin_mux_chk.sv
module spi_pin_mux_chk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       master_mode,
  input logic       tx_en,
  input logic       ser_dout,
  input logic       ser_sclk_out,
  input logic [3:0] gp_latch,
  input logic [3:0] gp_dir,
  input logic [3:0] pad_in,
  input logic [3:0] pad_out,
  input logic [3:0] pad_oe,
  input logic       ser_din
);
  localparam int unsigned WARM = SYNC_STAGES + RST_STAGES + 1;

  logic [SYNC_STAGES-1:0] hist_q;
  logic [7:0]             age_q;
  logic                   warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      age_q  <= '0;
    end else begin
      hist_q <= {hist_q[SYNC_STAGES-2:0], pad_in[3]};
      if (age_q != 8'hFF) age_q <= age_q + 8'd1;
    end
  end

  assign warm = (age_q >= 8'(WARM));

  AST_OFF_FOLLOWS_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (pad_oe == gp_dir) && (pad_out == gp_latch)); // R1

  AST_MST_DRIVES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && master_mode && gp_latch[1] && gp_latch[2]
      |-> pad_oe[1] && pad_oe[2] && (pad_out[1] == ser_dout) && (pad_out[2] == ser_sclk_out)); // R2

  AST_MST_SEL_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && master_mode |-> (pad_oe[3] == gp_dir[3]) && (pad_out[3] == gp_latch[3])); // R3

  AST_DIN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && gp_latch[0] |-> !pad_oe[0] && (ser_din == pad_in[0])); // R4

  AST_SLV_CLK_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && !master_mode && gp_latch[2] |-> !pad_oe[2]); // R5

  AST_SLV_DOUT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    warm && port_en && !master_mode && tx_en && gp_latch[1] && (hist_q == '0)
      |-> pad_oe[1] && (pad_out[1] == ser_dout)); // R6

  AST_SLV_DOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && !master_mode && gp_latch[1] && (!tx_en || (hist_q == '1))
      |-> !pad_oe[1]); // R7

  AST_LATCH0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && !gp_latch[0] |-> pad_oe[0] && !pad_out[0]); // R8
endmodule

bind spi_pin_mux spi_pin_mux_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .RST_STAGES (RST_STAGES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_en     (port_en),
  .master_mode (master_mode),
  .tx_en       (tx_en),
  .ser_dout    (ser_dout),
  .ser_sclk_out(ser_sclk_out),
  .gp_latch    (gp_latch),
  .gp_dir      (gp_dir),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .ser_din     (ser_din)
);

// File: tb/spi_pin_mux_tb.sv
module spi_pin_mux_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       port_en, master_mode, tx_en, ser_dout, ser_sclk_out;
  logic [3:0] gp_latch, gp_dir, pad_in;
  logic [3:0] pad_out, pad_oe;
  logic       ser_din, ser_sclk_in, ser_sel_act;

  int checks = 0;
  int errors = 0;
  logic m1, m2;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pin_mux u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .master_mode(master_mode),
    .tx_en(tx_en), .ser_dout(ser_dout), .ser_sclk_out(ser_sclk_out),
    .gp_latch(gp_latch), .gp_dir(gp_dir), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ser_din(ser_din),
    .ser_sclk_in(ser_sclk_in), .ser_sel_act(ser_sel_act)
  );

  // Select level as seen after two edges (R7, R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m1 <= 1'b1; m2 <= 1'b1; end
    else        begin m1 <= pad_in[3]; m2 <= m1; end
  end

  function automatic logic [7:0] exp_pins(logic sel);
    logic [3:0] own, drv, val, oe, out;
    own = {~master_mode & port_en, port_en, port_en, port_en};
    drv = 4'b0;
    drv[1] = port_en & (master_mode | (tx_en & ~sel));
    drv[2] = port_en & master_mode;
    val = {1'b0, ser_sclk_out, ser_dout, 1'b0};
    for (int i = 0; i < 4; i++) begin
      if (!own[i])           begin oe[i] = gp_dir[i]; out[i] = gp_latch[i]; end
      else if (!gp_latch[i]) begin oe[i] = 1'b1;      out[i] = 1'b0;        end
      else                   begin oe[i] = drv[i];    out[i] = drv[i] & val[i]; end
    end
    return {oe, out};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    logic [7:0] e;
    e = exp_pins(m2);
    chk(req, {pad_oe, pad_out}, e);
    chk({req, " R4 din"}, ser_din, pad_in[0]);
    chk({req, " R5 sclk_in"}, ser_sclk_in, pad_in[2]);
    chk({req, " R7 sel_act"}, ser_sel_act, port_en & ~master_mode & ~m2);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    port_en = 0; master_mode = 0; tx_en = 0; ser_dout = 0; ser_sclk_out = 0;
    gp_latch = 4'hF; gp_dir = 4'h0; pad_in = 4'hF;
    repeat (3) @(negedge clk);
    chk("R1 reset", {pad_oe, pad_out}, {4'h0, 4'hF});
    rst_n = 1'b1;
    // Slave, selected pin high after reset: no drive (R9)
    port_en = 1; tx_en = 1; ser_dout = 1;
    repeat (5) @(negedge clk);
    chk("R9 dout idle after reset", pad_oe[1], 1'b0);
    chk("R5 slave clk/sel", {pad_oe[3], pad_oe[2]}, 2'b00);

    // Select latency, directed (R7, R6)
    pad_in[3] = 1'b0;
    @(negedge clk);
    chk("R7 one edge", pad_oe[1], 1'b0);
    @(negedge clk);
    chk("R7 two edges", pad_oe[1], 1'b1);
    chk("R6 dout value", pad_out[1], 1'b1);
    tx_en = 1'b0; #1;
    chk("R6 tx_en off", pad_oe[1], 1'b0);
    tx_en = 1'b1;
    pad_in[3] = 1'b1;
    @(negedge clk);
    chk("R7 release one edge", pad_oe[1], 1'b1);
    @(negedge clk);
    chk("R7 release two edges", pad_oe[1], 1'b0);

    // Master directed (R2, R3)
    master_mode = 1; gp_dir = 4'b1000; gp_latch = 4'b0111; ser_sclk_out = 1; #1;
    chk("R3 sel gpio", {pad_oe[3], pad_out[3]}, 2'b10);
    chk("R2 clk drive", {pad_oe[2], pad_out[2]}, 2'b11);
    // Latch 0 on serial pin (R8)
    gp_latch = 4'b1101; #1;
    chk("R8 latch0", {pad_oe[1], pad_out[1]}, 2'b10);
    // Disabled (R1)
    port_en = 0; gp_dir = 4'b0101; #1;
    chk("R1 disabled", {pad_oe, pad_out}, {4'b0101, 4'b1101});

    // Random sweep
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      port_en      = ($urandom % 4) != 0;
      master_mode  = $urandom;
      tx_en        = $urandom;
      ser_dout     = $urandom;
      ser_sclk_out = $urandom;
      gp_latch     = (($urandom % 3) == 0) ? 4'($urandom) : 4'hF;
      gp_dir       = 4'($urandom);
      pad_in[2:0]  = 3'($urandom);
      if (($urandom % 4) == 0) pad_in[3] = ~pad_in[3];
      #1;
      chk_all("R1/R2/R3/R6/R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule